// File: doc/BRIEF.md
# Pipeline Operand Bypass Unit

This block decides, for a five-stage pipeline with 32 architectural registers, where each operand should come from when an older instruction has produced it but has not yet written it back. It compares the source register numbers of consumers against the destination numbers of the two producers further down the pipe. Those producers are the instruction in the memory stage and the instruction in the write-back stage. From that comparison it drives the select codes and the operand multiplexers for the two ALU inputs in the execute stage.

The same comparison logic serves two further paths. The first feeds the two operands of a branch comparison done early in the decode stage. The second feeds the store-data input of the data memory when a store sits directly behind the load that produced its data. The unit is purely combinational and holds no state. The register file, ALU, stall control and pipeline registers belong to the surrounding pipeline.

Top module: `op_bypass_unit`

## Requirements
- R1: Each ALU operand select is two bits wide with three legal codes: 2'b00 passes the register value latched for the execute stage, 2'b10 passes the memory-stage result, and 2'b01 passes the write-back-stage result. The code 2'b11 never appears.
- R2: An ALU operand select is 2'b10 when the memory-stage instruction writes a register, its destination is nonzero, and that destination equals the operand's source number.
- R3: An ALU operand select is 2'b01 when the write-back-stage instruction writes a nonzero destination equal to the source number and the memory stage does not qualify under R2.
- R4: When both producer stages qualify for the same operand, the memory-stage (younger) result is chosen.
- R5: A producer whose destination is register 0 is never forwarded on any path, even with its write enable set.
- R6: Operand A is matched only against the execute-stage rs number and operand B only against the rt number, and each select is decided independently of the other.
- R7: Each ALU operand output equals the value named by its select code.
- R8: For a branch in decode, compare select C (rs side) or D (rt side) is 1 when the branch flag is set, the memory-stage instruction writes a nonzero destination, and that destination matches the decode-stage rs or rt number. The compare operand is then the memory-stage result; otherwise it is the register-file value.
- R9: The branch compare path never takes the write-back-stage result, even when that stage matches. It relies on the register file writing before it reads.
- R10: Store-data select is 1 when the memory stage holds a store, the write-back stage holds a load that writes a nonzero destination, and that destination equals the store's data register. The store data is then the loaded value; otherwise it is the store's own data value.
- R11: All outputs depend only on the present inputs. Applying the same input vector again gives the same outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs_idx | input | 5 | Source register rs of the instruction in execute |
| ex_rt_idx | input | 5 | Source register rt of the instruction in execute |
| ex_rs_val | input | 32 | Register-file value of rs carried into execute |
| ex_rt_val | input | 32 | Register-file value of rt carried into execute |
| exm_wr_en | input | 1 | Memory-stage instruction writes a register |
| exm_rd_idx | input | 5 | Memory-stage destination register |
| exm_result | input | 32 | Memory-stage ALU result |
| mwb_wr_en | input | 1 | Write-back-stage instruction writes a register |
| mwb_rd_idx | input | 5 | Write-back-stage destination register |
| mwb_result | input | 32 | Write-back-stage result (ALU or load data) |
| mwb_ld_en | input | 1 | Write-back-stage instruction is a load |
| id_br_en | input | 1 | Decode-stage instruction is a branch |
| id_rs_idx | input | 5 | Decode-stage rs number |
| id_rt_idx | input | 5 | Decode-stage rt number |
| id_rs_val | input | 32 | Register-file read of decode rs |
| id_rt_val | input | 32 | Register-file read of decode rt |
| exm_st_en | input | 1 | Memory-stage instruction is a store |
| exm_st_idx | input | 5 | Register supplying the store data |
| exm_st_val | input | 32 | Store data carried into the memory stage |
| fwd_a_sel | output | 2 | ALU operand A source code |
| fwd_b_sel | output | 2 | ALU operand B source code |
| alu_opa | output | 32 | Selected ALU operand A |
| alu_opb | output | 32 | Selected ALU operand B |
| cmp_c_sel | output | 1 | Branch compare rs operand uses memory-stage result |
| cmp_d_sel | output | 1 | Branch compare rt operand uses memory-stage result |
| cmp_opa | output | 32 | Branch compare operand on the rs side |
| cmp_opb | output | 32 | Branch compare operand on the rt side |
| st_sel | output | 1 | Store data uses the write-back load value |
| st_data | output | 32 | Data-memory write data |

## Verification
The bench targets three back-to-back writes of the same register, where both producer stages match. A design that let the older stage win there would hand the ALU a stale sum. Register 0 is given as destination with write enable high; a design that skipped the zero test would pass junk where the hardwired zero belongs. Vectors where the write-back stage matches a branch operand and the memory stage does not expose a compare path that wrongly takes the older result. Store-after-load vectors with a non-load producer or a zero destination catch a store-data bypass that fires too often. Random vectors drawn from a small register range make both operands collide with the same or different producers, so any coupling between operand A and operand B shows up.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SRC_REGF = 2'b00,
    SRC_MWB  = 2'b01,
    SRC_EXM  = 2'b10
  } alu_src_e;
endpackage

// File: rtl/fwd_alu_sel.sv
module fwd_alu_sel #(
  parameter int IDX_W   = 5,
  parameter int NUM_OPS = 2
) (
  input  logic [NUM_OPS-1:0][IDX_W-1:0] src_idx,
  input  logic                          exm_wr_en,
  input  logic [IDX_W-1:0]              exm_rd_idx,
  input  logic                          mwb_wr_en,
  input  logic [IDX_W-1:0]              mwb_rd_idx,
  output logic [NUM_OPS-1:0]            exm_hit,
  output logic [NUM_OPS-1:0]            mwb_hit,
  output logic [NUM_OPS-1:0][1:0]       sel
);
  function automatic logic producer_hit(input logic wr, input logic [IDX_W-1:0] rd,
                                        input logic [IDX_W-1:0] src);
    return wr && (rd != '0) && (rd == src);
  endfunction

  function automatic logic [1:0] pick(input logic young, input logic old);
    if (young)    return fwd_pkg::SRC_EXM;
    else if (old) return fwd_pkg::SRC_MWB;
    else          return fwd_pkg::SRC_REGF;
  endfunction

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    assign exm_hit[g] = producer_hit(exm_wr_en, exm_rd_idx, src_idx[g]);
    assign mwb_hit[g] = producer_hit(mwb_wr_en, mwb_rd_idx, src_idx[g]);
    assign sel[g]     = pick(exm_hit[g], mwb_hit[g]);
  end
endmodule

// File: rtl/fwd_cmp_sel.sv
module fwd_cmp_sel #(
  parameter int IDX_W   = 5,
  parameter int DATA_W  = 32,
  parameter int NUM_OPS = 2
) (
  input  logic                           br_en,
  input  logic [NUM_OPS-1:0][IDX_W-1:0]  src_idx,
  input  logic [NUM_OPS-1:0][DATA_W-1:0] rf_val,
  input  logic                           exm_wr_en,
  input  logic [IDX_W-1:0]               exm_rd_idx,
  input  logic [DATA_W-1:0]              exm_result,
  output logic [NUM_OPS-1:0]             sel,
  output logic [NUM_OPS-1:0][DATA_W-1:0] opnd
);
  function automatic logic cmp_hit(input logic br, input logic wr,
                                   input logic [IDX_W-1:0] rd, input logic [IDX_W-1:0] src);
    return br && wr && (rd != '0) && (rd == src);
  endfunction

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_cmp
    assign sel[g]  = cmp_hit(br_en, exm_wr_en, exm_rd_idx, src_idx[g]);
    assign opnd[g] = sel[g] ? exm_result : rf_val[g];
  end
endmodule

// File: rtl/fwd_store_sel.sv
module fwd_store_sel #(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              st_en,
  input  logic [IDX_W-1:0]  st_idx,
  input  logic [DATA_W-1:0] st_val,
  input  logic              ld_en,
  input  logic              ld_wr_en,
  input  logic [IDX_W-1:0]  ld_rd_idx,
  input  logic [DATA_W-1:0] ld_data,
  output logic              sel,
  output logic [DATA_W-1:0] data
);
  function automatic logic ld_st_hit(input logic st, input logic ld, input logic wr,
                                     input logic [IDX_W-1:0] rd, input logic [IDX_W-1:0] src);
    return st && ld && wr && (rd != '0) && (rd == src);
  endfunction

  assign sel  = ld_st_hit(st_en, ld_en, ld_wr_en, ld_rd_idx, st_idx);
  assign data = sel ? ld_data : st_val;
endmodule

// File: rtl/fwd_opnd_mux.sv
module fwd_opnd_mux #(
  parameter int DATA_W  = 32,
  parameter int NUM_OPS = 2
) (
  input  logic [NUM_OPS-1:0][1:0]        sel,
  input  logic [NUM_OPS-1:0][DATA_W-1:0] regf_val,
  input  logic [DATA_W-1:0]              exm_val,
  input  logic [DATA_W-1:0]              mwb_val,
  output logic [NUM_OPS-1:0][DATA_W-1:0] opnd
);
  for (genvar g = 0; g < NUM_OPS; g++) begin : g_mux
    always_comb begin
      unique case (sel[g])
        fwd_pkg::SRC_EXM: opnd[g] = exm_val;
        fwd_pkg::SRC_MWB: opnd[g] = mwb_val;
        default:          opnd[g] = regf_val[g];
      endcase
    end
  end
endmodule

// File: rtl/op_bypass_unit.sv
module op_bypass_unit #(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [IDX_W-1:0]  ex_rs_idx,
  input  logic [IDX_W-1:0]  ex_rt_idx,
  input  logic [DATA_W-1:0] ex_rs_val,
  input  logic [DATA_W-1:0] ex_rt_val,
  input  logic              exm_wr_en,
  input  logic [IDX_W-1:0]  exm_rd_idx,
  input  logic [DATA_W-1:0] exm_result,
  input  logic              mwb_wr_en,
  input  logic [IDX_W-1:0]  mwb_rd_idx,
  input  logic [DATA_W-1:0] mwb_result,
  input  logic              mwb_ld_en,
  input  logic              id_br_en,
  input  logic [IDX_W-1:0]  id_rs_idx,
  input  logic [IDX_W-1:0]  id_rt_idx,
  input  logic [DATA_W-1:0] id_rs_val,
  input  logic [DATA_W-1:0] id_rt_val,
  input  logic              exm_st_en,
  input  logic [IDX_W-1:0]  exm_st_idx,
  input  logic [DATA_W-1:0] exm_st_val,
  output logic [1:0]        fwd_a_sel,
  output logic [1:0]        fwd_b_sel,
  output logic [DATA_W-1:0] alu_opa,
  output logic [DATA_W-1:0] alu_opb,
  output logic              cmp_c_sel,
  output logic              cmp_d_sel,
  output logic [DATA_W-1:0] cmp_opa,
  output logic [DATA_W-1:0] cmp_opb,
  output logic              st_sel,
  output logic [DATA_W-1:0] st_data
);
  localparam int NUM_OPS = 2;

  logic [NUM_OPS-1:0][IDX_W-1:0]  alu_src_idx;
  logic [NUM_OPS-1:0][DATA_W-1:0] alu_regf_val;
  logic [NUM_OPS-1:0][1:0]        alu_sel;
  logic [NUM_OPS-1:0][DATA_W-1:0] alu_opnd;
  logic [NUM_OPS-1:0]             alu_exm_hit;
  logic [NUM_OPS-1:0]             alu_mwb_hit;
  logic [NUM_OPS-1:0][IDX_W-1:0]  cmp_src_idx;
  logic [NUM_OPS-1:0][DATA_W-1:0] cmp_regf_val;
  logic [NUM_OPS-1:0]             cmp_sel;
  logic [NUM_OPS-1:0][DATA_W-1:0] cmp_opnd;

  assign alu_src_idx  = {ex_rt_idx, ex_rs_idx};
  assign alu_regf_val = {ex_rt_val, ex_rs_val};
  assign cmp_src_idx  = {id_rt_idx, id_rs_idx};
  assign cmp_regf_val = {id_rt_val, id_rs_val};

  fwd_alu_sel #(.IDX_W(IDX_W), .NUM_OPS(NUM_OPS)) u_alu_sel (
    .src_idx(alu_src_idx), .exm_wr_en(exm_wr_en), .exm_rd_idx(exm_rd_idx),
    .mwb_wr_en(mwb_wr_en), .mwb_rd_idx(mwb_rd_idx),
    .exm_hit(alu_exm_hit), .mwb_hit(alu_mwb_hit), .sel(alu_sel)
  );

  fwd_opnd_mux #(.DATA_W(DATA_W), .NUM_OPS(NUM_OPS)) u_alu_mux (
    .sel(alu_sel), .regf_val(alu_regf_val), .exm_val(exm_result),
    .mwb_val(mwb_result), .opnd(alu_opnd)
  );

  fwd_cmp_sel #(.IDX_W(IDX_W), .DATA_W(DATA_W), .NUM_OPS(NUM_OPS)) u_cmp_sel (
    .br_en(id_br_en), .src_idx(cmp_src_idx), .rf_val(cmp_regf_val),
    .exm_wr_en(exm_wr_en), .exm_rd_idx(exm_rd_idx), .exm_result(exm_result),
    .sel(cmp_sel), .opnd(cmp_opnd)
  );

  fwd_store_sel #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_st_sel (
    .st_en(exm_st_en), .st_idx(exm_st_idx), .st_val(exm_st_val),
    .ld_en(mwb_ld_en), .ld_wr_en(mwb_wr_en), .ld_rd_idx(mwb_rd_idx),
    .ld_data(mwb_result), .sel(st_sel), .data(st_data)
  );

  assign fwd_a_sel = alu_sel[0];
  assign fwd_b_sel = alu_sel[1];
  assign alu_opa   = alu_opnd[0];
  assign alu_opb   = alu_opnd[1];
  assign cmp_c_sel = cmp_sel[0];
  assign cmp_d_sel = cmp_sel[1];
  assign cmp_opa   = cmp_opnd[0];
  assign cmp_opb   = cmp_opnd[1];
endmodule

// File: rtl/op_bypass_chk.sv
module op_bypass_chk #(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 32
) (
  input logic [IDX_W-1:0]  ex_rs_idx,
  input logic [IDX_W-1:0]  ex_rt_idx,
  input logic [DATA_W-1:0] ex_rs_val,
  input logic              exm_wr_en,
  input logic [IDX_W-1:0]  exm_rd_idx,
  input logic [DATA_W-1:0] exm_result,
  input logic              mwb_wr_en,
  input logic [IDX_W-1:0]  mwb_rd_idx,
  input logic [DATA_W-1:0] mwb_result,
  input logic [DATA_W-1:0] id_rs_val,
  input logic [DATA_W-1:0] exm_st_val,
  input logic [1:0]        fwd_a_sel,
  input logic [1:0]        fwd_b_sel,
  input logic [DATA_W-1:0] alu_opa,
  input logic              cmp_c_sel,
  input logic [DATA_W-1:0] cmp_opa,
  input logic              st_sel,
  input logic [DATA_W-1:0] st_data,
  input logic [1:0]        alu_exm_hit,
  input logic [1:0]        alu_mwb_hit
);
  logic known;
  assign known = !$isunknown({ex_rs_idx, ex_rt_idx, exm_wr_en, exm_rd_idx,
                              mwb_wr_en, mwb_rd_idx, fwd_a_sel, fwd_b_sel,
                              cmp_c_sel, st_sel});

  always_comb begin
    if (known) begin
      AST_SEL_LEGAL: assert (fwd_a_sel != 2'b11 && fwd_b_sel != 2'b11); // R1
      AST_YOUNG_WINS: assert (!alu_exm_hit[0] || fwd_a_sel == 2'b10); // R4
      AST_OLD_ONLY: assert (!(alu_mwb_hit[0] && !alu_exm_hit[0]) || fwd_a_sel == 2'b01); // R3
      AST_ZERO_NEVER: assert (ex_rs_idx != '0 || fwd_a_sel == 2'b00); // R5
      AST_NO_STRAY_B: assert (ex_rt_idx != '0 || fwd_b_sel == 2'b00); // R6
      AST_MUX_A: assert (fwd_a_sel != 2'b01 || alu_opa == mwb_result); // R7
      AST_MUX_A_RF: assert (fwd_a_sel != 2'b00 || alu_opa == ex_rs_val); // R7
      AST_CMP_PATH: assert (cmp_c_sel ? (cmp_opa == exm_result) : (cmp_opa == id_rs_val)); // R8
      AST_ST_PATH: assert (st_sel ? (st_data == mwb_result) : (st_data == exm_st_val)); // R10
    end
  end
endmodule

bind op_bypass_unit op_bypass_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_op_bypass_unit.sv
module tb_op_bypass_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [4:0]  ex_rs_idx = '0, ex_rt_idx = '0, exm_rd_idx = '0, mwb_rd_idx = '0;
  logic [4:0]  id_rs_idx = '0, id_rt_idx = '0, exm_st_idx = '0;
  logic [31:0] ex_rs_val = '0, ex_rt_val = '0, exm_result = '0, mwb_result = '0;
  logic [31:0] id_rs_val = '0, id_rt_val = '0, exm_st_val = '0;
  logic        exm_wr_en = 1'b0, mwb_wr_en = 1'b0, mwb_ld_en = 1'b0;
  logic        id_br_en = 1'b0, exm_st_en = 1'b0;
  logic [1:0]  fwd_a_sel, fwd_b_sel;
  logic [31:0] alu_opa, alu_opb, cmp_opa, cmp_opb, st_data;
  logic        cmp_c_sel, cmp_d_sel, st_sel;

  op_bypass_unit dut (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected-value model, written from the requirements
  function automatic logic [1:0] exp_alu(input logic [4:0] src);
    logic young, old;
    young = exm_wr_en && exm_rd_idx == src && src != 5'd0;
    old   = mwb_wr_en && mwb_rd_idx == src && src != 5'd0;
    return young ? 2'b10 : (old ? 2'b01 : 2'b00);
  endfunction

  function automatic logic [31:0] exp_val(input logic [1:0] s, input logic [31:0] rf);
    case (s)
      2'b10:   return exm_result;
      2'b01:   return mwb_result;
      default: return rf;
    endcase
  endfunction

  function automatic logic exp_cmp(input logic [4:0] src);
    return id_br_en && exm_wr_en && src != 5'd0 && exm_rd_idx == src;
  endfunction

  function automatic logic exp_st();
    return exm_st_en && mwb_ld_en && mwb_wr_en && mwb_rd_idx != 5'd0 && mwb_rd_idx == exm_st_idx;
  endfunction

  task automatic check_all(input string tag);
    logic [1:0] ea, eb;
    ea = exp_alu(ex_rs_idx);
    eb = exp_alu(ex_rt_idx);
    check({"R2 R3 R4 R5 R6 sel A ", tag}, {30'd0, fwd_a_sel}, {30'd0, ea});
    check({"R2 R3 R4 R5 R6 sel B ", tag}, {30'd0, fwd_b_sel}, {30'd0, eb});
    check({"R7 opA ", tag}, alu_opa, exp_val(ea, ex_rs_val));
    check({"R7 opB ", tag}, alu_opb, exp_val(eb, ex_rt_val));
    check({"R8 R9 cmpC ", tag}, {31'd0, cmp_c_sel}, {31'd0, exp_cmp(id_rs_idx)});
    check({"R8 R9 cmpD ", tag}, {31'd0, cmp_d_sel}, {31'd0, exp_cmp(id_rt_idx)});
    check({"R8 R9 cmpA val ", tag}, cmp_opa, exp_cmp(id_rs_idx) ? exm_result : id_rs_val);
    check({"R8 R9 cmpB val ", tag}, cmp_opb, exp_cmp(id_rt_idx) ? exm_result : id_rt_val);
    check({"R10 st sel ", tag}, {31'd0, st_sel}, {31'd0, exp_st()});
    check({"R10 st data ", tag}, st_data, exp_st() ? mwb_result : exm_st_val);
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic rand_vec(input bit wide);
    ex_rs_idx  = wide ? 5'($urandom) : 5'($urandom % 4);
    ex_rt_idx  = wide ? 5'($urandom) : 5'($urandom % 4);
    exm_rd_idx = wide ? 5'($urandom) : 5'($urandom % 4);
    mwb_rd_idx = wide ? 5'($urandom) : 5'($urandom % 4);
    id_rs_idx  = 5'($urandom % 4);
    id_rt_idx  = 5'($urandom % 4);
    exm_st_idx = 5'($urandom % 4);
    ex_rs_val  = $urandom; ex_rt_val  = $urandom;
    exm_result = $urandom; mwb_result = $urandom;
    id_rs_val  = $urandom; id_rt_val  = $urandom; exm_st_val = $urandom;
    exm_wr_en  = 1'($urandom); mwb_wr_en = 1'($urandom); mwb_ld_en = 1'($urandom);
    id_br_en   = 1'($urandom); exm_st_en = 1'($urandom);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    rst = 1'b0;

    // Idle inputs: every select at the register-file code (R1)
    ex_rs_val = 32'h1111_0000; ex_rt_val = 32'h2222_0000;
    settle();
    check("R1 idle sel A", {30'd0, fwd_a_sel}, 32'd0);
    check("R1 idle opA", alu_opa, 32'h1111_0000);
    check_all("idle");

    // add r1 / add r1 / add r1: newest value must reach ALU (R4)
    ex_rs_idx = 5'd1; ex_rt_idx = 5'd4;
    exm_wr_en = 1'b1; exm_rd_idx = 5'd1; exm_result = 32'h0000_0030;
    mwb_wr_en = 1'b1; mwb_rd_idx = 5'd1; mwb_result = 32'h0000_0010;
    settle();
    check("R4 chain sel A", {30'd0, fwd_a_sel}, 32'd2);
    check("R4 chain opA", alu_opa, 32'h0000_0030);
    check("R6 chain sel B", {30'd0, fwd_b_sel}, 32'd0);

    // Memory stage does not write: older wins (R3)
    exm_wr_en = 1'b0;
    settle();
    check("R3 old only sel A", {30'd0, fwd_a_sel}, 32'd1);
    check("R3 old only opA", alu_opa, 32'h0000_0010);

    // Register 0 destination with write enable (R5)
    ex_rs_idx = 5'd0; ex_rt_idx = 5'd0;
    exm_wr_en = 1'b1; exm_rd_idx = 5'd0; mwb_rd_idx = 5'd0;
    id_br_en = 1'b1; id_rs_idx = 5'd0;
    settle();
    check("R5 zero sel A", {30'd0, fwd_a_sel}, 32'd0);
    check("R5 zero sel B", {30'd0, fwd_b_sel}, 32'd0);
    check("R5 zero cmpC", {31'd0, cmp_c_sel}, 32'd0);

    // Branch: write-back matches, memory stage does not (R9)
    id_rs_idx = 5'd7; id_rs_val = 32'hCAFE_0007;
    mwb_rd_idx = 5'd7; exm_rd_idx = 5'd9;
    settle();
    check("R9 no wb bypass sel", {31'd0, cmp_c_sel}, 32'd0);
    check("R9 no wb bypass val", cmp_opa, 32'hCAFE_0007);
    exm_rd_idx = 5'd7;
    settle();
    check("R8 cmp bypass", cmp_opa, exm_result);

    // Load then store of loaded register (R10), then non-load producer
    exm_st_en = 1'b1; exm_st_idx = 5'd7; mwb_ld_en = 1'b1; exm_st_val = 32'h5;
    settle();
    check("R10 ld->st data", st_data, mwb_result);
    mwb_ld_en = 1'b0;
    settle();
    check("R10 non-load no bypass", st_data, 32'h5);

    // Independent operands hitting different producers (R6)
    ex_rs_idx = 5'd7; ex_rt_idx = 5'd3; exm_rd_idx = 5'd3; mwb_rd_idx = 5'd7;
    settle();
    check("R6 split sel A", {30'd0, fwd_a_sel}, 32'd1);
    check("R6 split sel B", {30'd0, fwd_b_sel}, 32'd2);

    // Same vector again: no state (R11)
    settle();
    check("R11 repeat sel A", {30'd0, fwd_a_sel}, 32'd1);
    check("R11 repeat opB", alu_opb, exm_result);

    for (int i = 0; i < 3000; i++) begin
      rand_vec(i % 5 == 0);
      settle();
      check_all("random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule